// File: doc/BRIEF.md
# Dual GPIO Port Interrupt Controller

This block holds the registers of two 8-pin general-purpose I/O ports, A and B, and turns pin activity into one interrupt request. Each port has an output latch, a per-pin output enable, and a set of per-pin interrupt controls: a mode bit (level or edge), a sense bit (low/falling or high/rising), an enable, an optional debounce filter, a status readout and a write-one-to-clear acknowledge register. Software configures it over a simple synchronous register bus with a byte address, a write strobe, byte write data and registered read data.

Pin inputs are resynchronised by two flip-flops. Edges are found by comparing the conditioned pin with its value one cycle earlier, and are held until software acknowledges them. Level interrupts are not held: they follow the pin. The enabled status bits of both ports are ORed into a single registered request line. Software can emulate triggering on both edges by flipping the sense bit after each edge.

Top module: `gpio_irq_pair`

## Requirements
- R1: After reset every register reads 0x00, all output enables and output pins are low, and `irq` is low.
- R2: `pin_x_out` equals the port's data register and `pin_x_oe` equals its direction register (1 = output), one cycle after the write. A read of the data register returns the latch for output pins and the synchronised pin for input pins.
- R3: With the mode bit at 0 (level), the status bit is 1 while the pin is enabled and the pin is high (sense 1) or low (sense 0). The bit is not held: it drops when the level goes away.
- R4: With the mode bit at 1 (edge), a rising edge (sense 1) or a falling edge (sense 0) on an enabled pin sets a pending bit. It stays set after the pin returns, until it is acknowledged. An edge of the opposite direction sets nothing.
- R5: Writing the acknowledge register clears the pending edge bits written as 1. Bits written as 0 have no effect, and a level-mode status bit is not affected at all.
- R6: A pin whose enable bit is 0 shows status 0. Clearing the enable (or the mode bit) discards a pending edge, so re-enabling does not bring it back.
- R7: With the debounce bit set, a new pin value is accepted only after it has been seen on DB_COUNT consecutive sample ticks, one tick every TICK_DIV clocks. A shorter pulse is ignored; without debounce the same pulse is detected.
- R8: `irq` is the OR of all status bits of both ports, registered one cycle after the status.
- R9: Register byte offsets, port A / port B: data 0x00/0x04, direction 0x10/0x14, mode 0x90/0xAC, sense 0x94/0xB0, acknowledge 0x98/0xB4 (reads 0), enable 0x9C/0xB8, status 0xA0/0xBC (read only), debounce 0xA8/0xC4. The two ports are fully independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, for the offset of the previous cycle |
| pin_a_in | input | 8 | Port A pin inputs |
| pin_b_in | input | 8 | Port B pin inputs |
| pin_a_out | output | 8 | Port A output latch |
| pin_b_out | output | 8 | Port B output latch |
| pin_a_oe | output | 8 | Port A output enables |
| pin_b_oe | output | 8 | Port B output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with TICK_DIV = 4 and DB_COUNT = 4, so a debounce decision takes about sixteen clocks. Within a short run that lets an eight-cycle glitch be rejected and a forty-cycle hold be accepted, and the outcome is compared against a two-cycle pulse on an unfiltered pin. The default divider stays large, as a real debounce would need. The level cases of both senses and both enable states come from one table. The edge cases of both directions, the acknowledge mask and the enable drop are directed tests on port B, so the tests also show that port A is unaffected.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int NPORT  = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] data;
    logic [ADDR_W-1:0] dir;
    logic [ADDR_W-1:0] mode;
    logic [ADDR_W-1:0] sense;
    logic [ADDR_W-1:0] ack;
    logic [ADDR_W-1:0] en;
    logic [ADDR_W-1:0] sts;
    logic [ADDR_W-1:0] db;
  } reg_map_t;

  localparam reg_map_t MAP_A = '{data: 8'h00, dir: 8'h10, mode: 8'h90, sense: 8'h94,
                                 ack: 8'h98, en: 8'h9C, sts: 8'hA0, db: 8'hA8};
  localparam reg_map_t MAP_B = '{data: 8'h04, dir: 8'h14, mode: 8'hAC, sense: 8'hB0,
                                 ack: 8'hB4, en: 8'hB8, sts: 8'hBC, db: 8'hC4};

  typedef struct packed {
    logic data;
    logic dir;
    logic mode;
    logic sense;
    logic ack;
    logic en;
    logic db;
  } reg_wr_t;

  function automatic reg_map_t map_of(input int p);
    return (p == 0) ? MAP_A : MAP_B;
  endfunction
endpackage

// File: rtl/gpio_tick_div.sv
module gpio_tick_div #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int W        = 8,
  parameter int DB_COUNT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] db_en,
  output logic [W-1:0] sync,
  output logic [W-1:0] filt
);
  localparam int DCW = $clog2(DB_COUNT + 1);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      sync <= '0;
    end else begin
      s1   <= raw;
      sync <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic           held;
    logic [DCW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        held <= 1'b0;
        cnt  <= '0;
      end else if (!db_en[i]) begin
        held <= sync[i];
        cnt  <= '0;
      end else if (tick) begin
        if (sync[i] == held) begin
          cnt <= '0;
        end else if (cnt == DCW'(DB_COUNT - 1)) begin
          held <= sync[i];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign filt[i] = db_en[i] ? held : sync[i];
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W        = BYTE_W,
  parameter int DB_COUNT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] pin_in,
  input  reg_wr_t      wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] sense_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] db_q,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] status,
  output logic [W-1:0] pend
);
  logic [W-1:0] sync, filt, prev;
  logic [W-1:0] en_nxt, mode_nxt, ack_mask, rise, fall, hit, lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
      sense_q <= '0;
      en_q    <= '0;
      db_q    <= '0;
    end else begin
      if (wr.data)  data_q  <= wdata;
      if (wr.dir)   dir_q   <= wdata;
      if (wr.mode)  mode_q  <= wdata;
      if (wr.sense) sense_q <= wdata;
      if (wr.en)    en_q    <= wdata;
      if (wr.db)    db_q    <= wdata;
    end
  end

  gpio_pin_filter #(.W(W), .DB_COUNT(DB_COUNT)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .raw  (pin_in),
    .db_en(db_q),
    .sync (sync),
    .filt (filt)
  );

  always_comb begin
    en_nxt   = wr.en   ? wdata : en_q;
    mode_nxt = wr.mode ? wdata : mode_q;
    ack_mask = wr.ack  ? wdata : '0;
    rise     = filt & ~prev;
    fall     = ~filt & prev;
    hit      = (sense_q & rise) | (~sense_q & fall);
    lvl      = ~(filt ^ sense_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= filt;
      pend <= ((pend & ~ack_mask) | hit) & en_nxt & mode_nxt;
    end
  end

  assign status = en_q & ((mode_q & pend) | (~mode_q & lvl));
  assign pin_rd = (data_q & dir_q) | (sync & ~dir_q);
endmodule

// File: rtl/gpio_irq_pair.sv
module gpio_irq_pair
  import gpio_irq_pkg::*;
#(
  parameter int TICK_DIV = 250,
  parameter int DB_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  pin_a_in,
  input  logic [7:0]  pin_b_in,
  output logic [7:0]  pin_a_out,
  output logic [7:0]  pin_b_out,
  output logic [7:0]  pin_a_oe,
  output logic [7:0]  pin_b_oe,
  output logic        irq
);
  localparam int W = BYTE_W;

  logic                tick;
  logic [NPORT-1:0][W-1:0] pins, data_q, dir_q, mode_q, sense_q, en_q, db_q;
  logic [NPORT-1:0][W-1:0] pin_rd, status, pend;
  logic [W-1:0]        rd_nxt;
  logic [W-1:0]        stat_a, stat_b, pend_a;

  gpio_tick_div #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  assign pins[0] = pin_a_in;
  assign pins[1] = pin_b_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam reg_map_t M = map_of(p);
    reg_wr_t wr;

    always_comb begin
      wr.data  = wr_en && (addr == M.data);
      wr.dir   = wr_en && (addr == M.dir);
      wr.mode  = wr_en && (addr == M.mode);
      wr.sense = wr_en && (addr == M.sense);
      wr.ack   = wr_en && (addr == M.ack);
      wr.en    = wr_en && (addr == M.en);
      wr.db    = wr_en && (addr == M.db);
    end

    gpio_irq_port #(.W(W), .DB_COUNT(DB_COUNT)) u_port (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .pin_in (pins[p]),
      .wr     (wr),
      .wdata  (wdata),
      .data_q (data_q[p]),
      .dir_q  (dir_q[p]),
      .mode_q (mode_q[p]),
      .sense_q(sense_q[p]),
      .en_q   (en_q[p]),
      .db_q   (db_q[p]),
      .pin_rd (pin_rd[p]),
      .status (status[p]),
      .pend   (pend[p])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr == map_of(p).data)  rd_nxt = pin_rd[p];
      if (addr == map_of(p).dir)   rd_nxt = dir_q[p];
      if (addr == map_of(p).mode)  rd_nxt = mode_q[p];
      if (addr == map_of(p).sense) rd_nxt = sense_q[p];
      if (addr == map_of(p).en)    rd_nxt = en_q[p];
      if (addr == map_of(p).sts)   rd_nxt = status[p];
      if (addr == map_of(p).db)    rd_nxt = db_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_nxt;
      irq   <= |status;
    end
  end

  assign pin_a_out = data_q[0];
  assign pin_b_out = data_q[1];
  assign pin_a_oe  = dir_q[0];
  assign pin_b_oe  = dir_q[1];
  assign stat_a    = status[0];
  assign stat_b    = status[1];
  assign pend_a    = pend[0];
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] pin_a_oe,
  input logic [7:0] stat_a,
  input logic [7:0] stat_b,
  input logic [7:0] pend_a,
  input logic       irq
);
  // R1: the cycle after reset leaves the request and enables low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && pin_a_oe == 8'h00));

  // R2: a direction write reaches the enables on the next cycle
  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MAP_A.dir) |=> (pin_a_oe == $past(wdata)));

  // R4: a pending edge only drops on an acknowledge, enable or mode write
  assert_edge_held_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == MAP_A.ack || addr == MAP_A.en || addr == MAP_A.mode))
    |=> (($past(pend_a) & ~pend_a) == 8'h00));

  // R6: writing an all-zero enable silences the port's status
  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MAP_A.en && wdata == 8'h00) |=> (stat_a == 8'h00));

  // R8: the request is the registered OR of both ports' status
  assert_irq_or_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|{stat_a, stat_b})));
endmodule

bind gpio_irq_pair gpio_irq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .wdata   (wdata),
  .pin_a_oe(pin_a_oe),
  .stat_a  (stat_a),
  .stat_b  (stat_b),
  .pend_a  (pend_a),
  .irq     (irq)
);

// File: tb/tb_gpio_irq_pair.sv
module tb_gpio_irq_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pin_a = 8'h00;
  logic [7:0] pin_b = 8'h00;
  logic [7:0] rdata, pin_a_out, pin_b_out, pin_a_oe, pin_b_oe;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  gpio_irq_pair #(.TICK_DIV(4), .DB_COUNT(4)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_a_in(pin_a), .pin_b_in(pin_b), .pin_a_out(pin_a_out), .pin_b_out(pin_b_out),
    .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe), .irq(irq)
  );

  // {sense, enable, pin, expected status} for pin A0 in level mode
  localparam logic [3:0] LVL_VEC [6] = '{4'b1111, 4'b1100, 4'b0101,
                                         4'b0110, 4'b1010, 4'b0000};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    settle(4);
    rst = 1'b0;
    settle(2);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 oe", pin_a_oe | pin_b_oe, 8'h00);
    rd(8'hA0, v); chk("R1 status A", v, 8'h00);
    rd(8'hAC, v); chk("R1 mode B", v, 8'h00);

    // R2 data and direction
    pin_a = 8'h0F;
    wr(8'h10, 8'hF0);
    wr(8'h00, 8'hA5);
    chk("R2 oe", pin_a_oe, 8'hF0);
    chk("R2 out", pin_a_out, 8'hA5);
    rd(8'h00, v); chk("R2 data read", v, 8'hAF);
    wr(8'h10, 8'h00);
    pin_a = 8'h00;
    settle(4);

    // R3 R6 R8 level table on pin A0
    wr(8'h90, 8'h00);
    for (int k = 0; k < 6; k++) begin
      wr(8'h94, {7'b0, LVL_VEC[k][3]});
      wr(8'h9C, {7'b0, LVL_VEC[k][2]});
      pin_a = {7'b0, LVL_VEC[k][1]};
      settle(6);
      rd(8'hA0, v); chk($sformatf("R3 level row %0d", k), v, {7'b0, LVL_VEC[k][0]});
      chk($sformatf("R8 irq row %0d", k), {7'b0, irq}, {7'b0, LVL_VEC[k][0]});
    end
    // R5 acknowledge leaves level status alone
    wr(8'h94, 8'h01); wr(8'h9C, 8'h01); pin_a = 8'h01; settle(6);
    wr(8'h98, 8'h01); settle(4);
    rd(8'hA0, v); chk("R5 level ack ignored", v, 8'h01);
    wr(8'h9C, 8'h00); pin_a = 8'h00; settle(6);

    // R4 R5 R9 rising edge on B3
    wr(8'hAC, 8'h08); wr(8'hB0, 8'h08); wr(8'hB8, 8'h08); settle(4);
    rd(8'hBC, v); chk("R4 idle", v, 8'h00);
    pin_b = 8'h08; settle(6);
    rd(8'hBC, v); chk("R4 rise latched", v, 8'h08);
    chk("R8 irq edge", {7'b0, irq}, 8'h01);
    rd(8'hA0, v); chk("R9 port A untouched", v, 8'h00);
    pin_b = 8'h00; settle(6);
    rd(8'hBC, v); chk("R4 held after pin low", v, 8'h08);
    wr(8'hB4, 8'h00); settle(2);
    rd(8'hBC, v); chk("R5 zero ack", v, 8'h08);
    wr(8'hB4, 8'hF7); settle(2);
    rd(8'hBC, v); chk("R5 other bits ack", v, 8'h08);
    wr(8'hB4, 8'h08); settle(3);
    rd(8'hBC, v); chk("R5 ack clears", v, 8'h00);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);
    // R4 falling sense
    wr(8'hB0, 8'h00);
    pin_b = 8'h08; settle(6);
    rd(8'hBC, v); chk("R4 rise ignored when falling", v, 8'h00);
    pin_b = 8'h00; settle(6);
    rd(8'hBC, v); chk("R4 fall latched", v, 8'h08);
    wr(8'hB4, 8'h08);
    // R6 disabling drops a pending edge
    wr(8'hB0, 8'h08); pin_b = 8'h08; settle(6);
    rd(8'hBC, v); chk("R6 pending before drop", v, 8'h08);
    wr(8'hB8, 8'h00); settle(2);
    rd(8'hBC, v); chk("R6 disabled", v, 8'h00);
    wr(8'hB8, 8'h08); settle(2);
    rd(8'hBC, v); chk("R6 not restored", v, 8'h00);
    rd(8'hB0, v); chk("R9 sense B readback", v, 8'h08);

    // R7 debounce on A1
    wr(8'h90, 8'h02); wr(8'h94, 8'h02); wr(8'hA8, 8'h02); wr(8'h9C, 8'h02);
    settle(10);
    pin_a = 8'h02; settle(8); pin_a = 8'h00; settle(40);
    rd(8'hA0, v); chk("R7 glitch rejected", v, 8'h00);
    pin_a = 8'h02; settle(40);
    rd(8'hA0, v); chk("R7 hold accepted", v, 8'h02);
    rd(8'hA8, v); chk("R9 debounce readback", v, 8'h02);
    wr(8'h98, 8'h02);
    wr(8'h90, 8'h06); wr(8'h94, 8'h06); wr(8'h9C, 8'h06); settle(4);
    pin_a = 8'h06; settle(2); pin_a = 8'h02; settle(10);
    rd(8'hA0, v); chk("R7 short pulse seen unfiltered", v, 8'h04);

    finish_run();
  end
endmodule